// File: doc/BRIEF.md
# Virtual Clock Affine Converter

This block produces the time of a software-steered slave clock without ever running that clock. A free-running raw counter advances by one on every clock edge and nothing can load, pause or trim it. The precise time is computed only when someone asks for it, as the raw value multiplied by an unsigned rate factor A plus a signed offset B. The servo steers rate and phase by changing A and B alone.

Two kinds of request share one request/response handshake. The first is a queued raw timestamp that arrives on the request bus. The second is a live read, which converts a snapshot of the raw counter taken in the cycle the request is accepted. The rate factor is a Q8.32 unsigned value. The offset is a 64-bit two's-complement value. Both are written into shadow registers and become active together on a commit strobe, so a single conversion always uses a matched pair.

The product is formed by a shift-and-add multiplier that handles one bit of A per cycle. While it is busy, new requests are refused. A one-cycle done strobe marks each result, and the result stays on the outputs until the next one replaces it.

Top module: `vca_affine_conv`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0, `resp_time` and `resp_raw` are 0, the active A is 1.0 (40'h01_0000_0000) and the active B is 0.
- R2: A response carries `resp_time` = ((raw × A) >> 32) + B modulo 2^64. Here raw is 48-bit unsigned, A is 40-bit unsigned with 32 fractional bits, and B is 64-bit signed.
- R3: A request is accepted at a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from that edge until the edge that raises `resp_valid`. That edge comes exactly 40 edges after acceptance. `resp_valid` is high for one cycle, and `req_ready` is 1 in that same cycle.
- R4: With `req_live` = 1, the raw value converted is the raw counter value during the accept cycle. The counter holds the number of edges since reset release, modulo 2^48. With `req_live` = 0, the value on `req_ts` is used. `resp_raw` reports the raw value converted. No input alters the counter.
- R5: A `req_valid` while `req_ready` is 0 is ignored. It produces no response, and it does not change the pending result or its timing.
- R6: Writes to the A and B shadow registers have no effect on any conversion until a commit.
- R7: A commit copies both shadows into the active pair at the same edge. A conversion uses the pair that is active just before its accept edge. A commit at that same edge, or while the conversion runs, does not affect it.
- R8: The final addition wraps modulo 2^64. A negative B may produce a negative `resp_time`, and a large product plus B may wrap.
- R9: `resp_time` and `resp_raw` hold their value between responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_wr_en | input | 1 | Write the A shadow register |
| a_wr_data | input | 40 | New rate factor, Q8.32 unsigned |
| b_wr_en | input | 1 | Write the B shadow register |
| b_wr_data | input | 64 | New offset, signed |
| prm_commit | input | 1 | Copy both shadows to the active pair |
| req_valid | input | 1 | Conversion request |
| req_live | input | 1 | 1: snapshot the raw counter, 0: use req_ts |
| req_ts | input | 48 | Queued raw timestamp |
| req_ready | output | 1 | Converter idle, request can be accepted |
| resp_valid | output | 1 | One-cycle done strobe |
| resp_time | output | 64 | Converted precise time |
| resp_raw | output | 48 | Raw value that was converted |

## Verification
The hardest situations to reach are the ones where the parameter pair changes in the same cycle a conversion begins, or while it is part-way through. Those are exactly where an unmatched pair could slip in. The stimulus writes new shadow values in advance. It then raises the commit in the accept cycle of one request, and in the middle of the run of another request. The bench's per-cycle reference model predicts the old pair for both conversions and the new pair for the next one. Refused requests are probed by holding `req_valid` through the busy window with a different timestamp. Live snapshots are compared against a bench-side edge count.

// File: rtl/vca_pkg.sv
package vca_pkg;

  typedef enum logic {
    SRC_QUEUE = 1'b0,
    SRC_LIVE  = 1'b1
  } vca_src_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_MUL  = 1'b1
  } vca_state_e;

endpackage

// File: rtl/vca_raw_counter.sv
module vca_raw_counter #(
  parameter int unsigned RAW_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [RAW_W-1:0] cnt
);

  logic [RAW_W-1:0] cnt_q;
  logic [RAW_W-1:0] cnt_d;

  // free-running, no load or hold path exists
  always_comb begin
    cnt_d = cnt_q + RAW_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R4: counter advances by exactly one per edge
  a_r4_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt_q == $past(cnt_q) + RAW_W'(1));

endmodule

// File: rtl/vca_param_bank.sv
module vca_param_bank #(
  parameter int unsigned A_W    = 40,
  parameter int unsigned FRAC_W = 32,
  parameter int unsigned T_W    = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           a_wr_en,
  input  logic [A_W-1:0] a_wr_data,
  input  logic           b_wr_en,
  input  logic [T_W-1:0] b_wr_data,
  input  logic           commit,
  output logic [A_W-1:0] a_act,
  output logic [T_W-1:0] b_act
);

  localparam logic [A_W-1:0] A_UNITY = A_W'(1) << FRAC_W;

  logic [A_W-1:0] a_sh_q, a_sh_d, a_act_q, a_act_d;
  logic [T_W-1:0] b_sh_q, b_sh_d, b_act_q, b_act_d;
  logic           sh_a_en, sh_b_en, act_en;

  assign sh_a_en = a_wr_en;
  assign sh_b_en = b_wr_en;
  assign act_en  = commit;

  always_comb begin
    a_sh_d  = sh_a_en ? a_wr_data : a_sh_q;
    b_sh_d  = sh_b_en ? b_wr_data : b_sh_q;
    // commit takes the shadow value held before this edge
    a_act_d = act_en ? a_sh_q : a_act_q;
    b_act_d = act_en ? b_sh_q : b_act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sh_q  <= A_UNITY;
      b_sh_q  <= '0;
      a_act_q <= A_UNITY;
      b_act_q <= '0;
    end else begin
      a_sh_q  <= a_sh_d;
      b_sh_q  <= b_sh_d;
      a_act_q <= a_act_d;
      b_act_q <= b_act_d;
    end
  end

  assign a_act = a_act_q;
  assign b_act = b_act_q;

  // R6/R7: the active pair moves only on a commit
  a_r7_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(a_act_q) && $stable(b_act_q)));

endmodule

// File: rtl/vca_seq_mul.sv
module vca_seq_mul
  import vca_pkg::*;
#(
  parameter int unsigned RAW_W  = 48,
  parameter int unsigned A_W    = 40,
  parameter int unsigned FRAC_W = 32,
  parameter int unsigned T_W    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [RAW_W-1:0] raw_in,
  input  logic [A_W-1:0]   a_in,
  input  logic [T_W-1:0]   b_in,
  output logic             busy,
  output logic             done,
  output logic [T_W-1:0]   time_out,
  output logic [RAW_W-1:0] raw_out
);

  localparam int unsigned P_W   = RAW_W + A_W;
  localparam int unsigned SC_W  = P_W - FRAC_W;
  localparam int unsigned CNT_W = $clog2(A_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(A_W - 1);

  vca_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [P_W-1:0]   mcand_q, mcand_d;
  logic [A_W-1:0]   mplier_q, mplier_d;
  logic [P_W-1:0]   acc_q, acc_d;
  logic [T_W-1:0]   b_q, b_d;
  logic [RAW_W-1:0] hold_q, hold_d;
  logic [T_W-1:0]   time_q, time_d;
  logic [RAW_W-1:0] raw_q, raw_d;
  logic             done_q, done_d;

  logic [P_W-1:0]   partial;
  logic [P_W-1:0]   acc_sum;
  logic [T_W-1:0]   scaled;
  logic [T_W-1:0]   time_next;
  logic             out_en;

  assign partial = mplier_q[0] ? mcand_q : '0;
  assign acc_sum = acc_q + partial;

  // drop the fractional bits; width of the integer part picks the variant
  generate
    if (SC_W >= T_W) begin : g_trunc
      assign scaled = acc_sum[FRAC_W +: T_W];
    end else begin : g_zext
      assign scaled = {{(T_W - SC_W){1'b0}}, acc_sum[P_W-1:FRAC_W]};
    end
  endgenerate

  assign time_next = scaled + b_q;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    mcand_d  = mcand_q;
    mplier_d = mplier_q;
    acc_d    = acc_q;
    b_d      = b_q;
    hold_d   = hold_q;
    done_d   = 1'b0;
    out_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d  = ST_MUL;
          cnt_d    = '0;
          mcand_d  = {{A_W{1'b0}}, raw_in};
          mplier_d = a_in;
          acc_d    = '0;
          b_d      = b_in;
          hold_d   = raw_in;
        end
      end
      ST_MUL: begin
        acc_d    = acc_sum;
        mcand_d  = mcand_q << 1;
        mplier_d = mplier_q >> 1;
        cnt_d    = cnt_q + CNT_W'(1);
        if (cnt_q == LAST) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          out_en  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    time_d = out_en ? time_next : time_q;
    raw_d  = out_en ? hold_q    : raw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
      b_q      <= '0;
      hold_q   <= '0;
      time_q   <= '0;
      raw_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
      acc_q    <= acc_d;
      b_q      <= b_d;
      hold_q   <= hold_d;
      time_q   <= time_d;
      raw_q    <= raw_d;
      done_q   <= done_d;
    end
  end

  assign busy     = (state_q == ST_MUL);
  assign done     = done_q;
  assign time_out = time_q;
  assign raw_out  = raw_q;

  // R3: done is a single-cycle strobe
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R5: no result appears unless a conversion was running
  a_r5_no_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |=> !done_q);

  // R9: outputs change only together with the done strobe
  a_r9_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (done_q || ($stable(time_q) && $stable(raw_q))));

endmodule

// File: rtl/vca_affine_conv.sv
module vca_affine_conv
  import vca_pkg::*;
#(
  parameter int unsigned RAW_W  = 48,
  parameter int unsigned A_W    = 40,
  parameter int unsigned FRAC_W = 32,
  parameter int unsigned T_W    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_wr_en,
  input  logic [A_W-1:0]   a_wr_data,
  input  logic             b_wr_en,
  input  logic [T_W-1:0]   b_wr_data,
  input  logic             prm_commit,
  input  logic             req_valid,
  input  logic             req_live,
  input  logic [RAW_W-1:0] req_ts,
  output logic             req_ready,
  output logic             resp_valid,
  output logic [T_W-1:0]   resp_time,
  output logic [RAW_W-1:0] resp_raw
);

  logic [RAW_W-1:0] raw_now;
  logic [A_W-1:0]   a_act;
  logic [T_W-1:0]   b_act;
  logic [RAW_W-1:0] raw_sel;
  logic             busy;
  logic             accept;
  vca_src_e         src;

  vca_raw_counter #(.RAW_W(RAW_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (raw_now)
  );

  vca_param_bank #(.A_W(A_W), .FRAC_W(FRAC_W), .T_W(T_W)) u_prm (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_wr_en   (a_wr_en),
    .a_wr_data (a_wr_data),
    .b_wr_en   (b_wr_en),
    .b_wr_data (b_wr_data),
    .commit    (prm_commit),
    .a_act     (a_act),
    .b_act     (b_act)
  );

  assign src       = vca_src_e'(req_live);
  assign raw_sel   = (src == SRC_LIVE) ? raw_now : req_ts;
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  vca_seq_mul #(.RAW_W(RAW_W), .A_W(A_W), .FRAC_W(FRAC_W), .T_W(T_W)) u_mul (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .raw_in   (raw_sel),
    .a_in     (a_act),
    .b_in     (b_act),
    .busy     (busy),
    .done     (resp_valid),
    .time_out (resp_time),
    .raw_out  (resp_raw)
  );

  // R3: an accepted request closes the door on the next cycle
  a_r3_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R3: ready is back in the cycle the result is flagged
  a_r3_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> req_ready);

endmodule

// File: tb/vca_affine_conv_bench.sv
`timescale 1ns/1ps
module vca_affine_conv_bench;

  localparam int RAW_W  = 48;
  localparam int A_W    = 40;
  localparam int FRAC_W = 32;
  localparam int T_W    = 64;

  logic             clk;
  logic             rst_n;
  logic             a_wr_en;
  logic [A_W-1:0]   a_wr_data;
  logic             b_wr_en;
  logic [T_W-1:0]   b_wr_data;
  logic             prm_commit;
  logic             req_valid;
  logic             req_live;
  logic [RAW_W-1:0] req_ts;
  logic             req_ready;
  logic             resp_valid;
  logic [T_W-1:0]   resp_time;
  logic [RAW_W-1:0] resp_raw;

  int compared;
  int mismatched;
  bit finished;

  vca_affine_conv #(.RAW_W(RAW_W), .A_W(A_W), .FRAC_W(FRAC_W), .T_W(T_W)) u_vca_affine_conv (
    .clk(clk), .rst_n(rst_n),
    .a_wr_en(a_wr_en), .a_wr_data(a_wr_data),
    .b_wr_en(b_wr_en), .b_wr_data(b_wr_data),
    .prm_commit(prm_commit),
    .req_valid(req_valid), .req_live(req_live), .req_ts(req_ts),
    .req_ready(req_ready), .resp_valid(resp_valid),
    .resp_time(resp_time), .resp_raw(resp_raw)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  localparam logic [A_W-1:0] ONE = 40'h01_0000_0000;

  function automatic logic [T_W-1:0] conv(input logic [RAW_W-1:0] r,
                                          input logic [A_W-1:0] a,
                                          input logic [T_W-1:0] b);
    logic [87:0] p;
    p = 88'(r) * 88'(a);
    return {8'b0, p[87:32]} + b;
  endfunction

  // ---------------- behavioural reference model ----------------
  bit               m_init;
  logic [RAW_W-1:0] m_cnt;
  logic [A_W-1:0]   m_a_sh, m_a_act;
  logic [T_W-1:0]   m_b_sh, m_b_act;
  bit               m_busy;
  int               m_left;
  logic [T_W-1:0]   m_pend_time, m_time;
  logic [RAW_W-1:0] m_pend_raw, m_raw;
  bit               m_rv;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_init = 1'b1; m_cnt = '0;
      m_a_sh = ONE; m_a_act = ONE; m_b_sh = '0; m_b_act = '0;
      m_busy = 1'b0; m_left = 0; m_rv = 1'b0;
      m_pend_time = '0; m_pend_raw = '0; m_time = '0; m_raw = '0;
    end else begin
      m_rv = 1'b0;
      if (m_busy) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_busy = 1'b0; m_rv = 1'b1;
          m_time = m_pend_time; m_raw = m_pend_raw;
        end
      end else if (req_valid) begin
        m_pend_raw  = req_live ? m_cnt : req_ts;
        m_pend_time = conv(m_pend_raw, m_a_act, m_b_act);
        m_busy = 1'b1; m_left = A_W;
      end
      if (prm_commit) begin m_a_act = m_a_sh; m_b_act = m_b_sh; end
      if (a_wr_en) m_a_sh = a_wr_data;
      if (b_wr_en) m_b_sh = b_wr_data;
      m_cnt = m_cnt + 1'b1;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && m_init && !finished) begin
      compared++;
      if (req_ready !== !m_busy || resp_valid !== m_rv) begin
        mismatched++;
        $display("FAIL R3 cycle handshake: ready=%0b valid=%0b expected ready=%0b valid=%0b",
                 req_ready, resp_valid, !m_busy, m_rv);
      end
      compared++;
      if (resp_time !== m_time) begin
        mismatched++;
        $display("FAIL R2 resp_time: actual %h expected %h", resp_time, m_time);
      end
      compared++;
      if (resp_raw !== m_raw) begin
        mismatched++;
        $display("FAIL R4 resp_raw: actual %h expected %h", resp_raw, m_raw);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input logic [T_W-1:0] act, input logic [T_W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive_idle();
    a_wr_en = 0; b_wr_en = 0; prm_commit = 0; req_valid = 0; req_live = 0;
  endtask

  task automatic set_shadow(input logic [A_W-1:0] a, input logic [T_W-1:0] b, input bit do_commit);
    @(negedge clk); #1;
    a_wr_en = 1; a_wr_data = a; b_wr_en = 1; b_wr_data = b;
    @(negedge clk); #1;
    a_wr_en = 0; b_wr_en = 0;
    if (do_commit) begin
      prm_commit = 1;
      @(negedge clk); #1;
      prm_commit = 0;
    end
  endtask

  // issue one request from idle, wait for the result, check it
  task automatic run_conv(input bit live, input logic [RAW_W-1:0] ts,
                          input logic [A_W-1:0] a, input logic [T_W-1:0] b,
                          input bit commit_at_accept, input string tag);
    logic [RAW_W-1:0] exp_raw;
    int n;
    @(negedge clk); #1;
    req_valid = 1; req_live = live; req_ts = ts;
    prm_commit = commit_at_accept;
    exp_raw = live ? m_cnt : ts;
    n = 0;
    @(negedge clk);
    #1; req_valid = 0; prm_commit = 0;
    n = 1;
    while (!resp_valid && n < 200) begin
      @(negedge clk);
      if (!resp_valid) n++;
    end
    check({tag, " R3 latency"}, T_W'(n), T_W'(A_W));
    check({tag, " time"}, resp_time, conv(exp_raw, a, b));
    check("R4 converted raw", T_W'(resp_raw), T_W'(exp_raw));
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [T_W-1:0] held_time;
    int pulses;
    finished = 0; compared = 0; mismatched = 0;
    rst_n = 0; a_wr_data = '0; b_wr_data = '0; req_ts = '0;
    drive_idle();
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 ready", T_W'(req_ready), 1);
    check("R1 valid", T_W'(resp_valid), 0);
    check("R1 time", resp_time, 0);
    check("R1 raw", T_W'(resp_raw), 0);
    rst_n = 1;

    // R1/R2: identity pair after reset
    run_conv(0, 48'd12345, ONE, 0, 0, "R1 default pair");
    // R6: shadow write without commit changes nothing
    set_shadow(40'h02_8000_0000, 64'd1000, 0);
    run_conv(0, 48'd1000, ONE, 0, 0, "R6 uncommitted");
    // R7: commit in the accept cycle still uses the old pair
    run_conv(0, 48'd1000, ONE, 0, 1, "R7 commit at accept");
    run_conv(0, 48'd1000, 40'h02_8000_0000, 64'd1000, 0, "R2 scaled");
    // R4: live snapshots
    run_conv(1, 48'd0, 40'h02_8000_0000, 64'd1000, 0, "R4 live a");
    repeat (7) @(negedge clk);
    run_conv(1, 48'd0, 40'h02_8000_0000, 64'd1000, 0, "R4 live b");

    // R7: commit while a conversion runs
    set_shadow(40'h00_4000_0000, 64'd77, 0);
    @(negedge clk); #1;
    req_valid = 1; req_live = 0; req_ts = 48'd4096;
    @(negedge clk); #1;
    req_valid = 0;
    repeat (5) @(negedge clk);
    #1 prm_commit = 1;
    @(negedge clk); #1 prm_commit = 0;
    while (!resp_valid) @(negedge clk);
    check("R7 mid-run commit", resp_time, conv(48'd4096, 40'h02_8000_0000, 64'd1000));
    run_conv(0, 48'd4096, 40'h00_4000_0000, 64'd77, 0, "R7 after commit");

    // R5: requests while busy are refused
    @(negedge clk); #1;
    req_valid = 1; req_live = 0; req_ts = 48'd111;
    @(negedge clk); #1;
    req_ts = 48'd999;
    repeat (10) @(negedge clk);
    #1 req_valid = 0;
    pulses = 0;
    while (!resp_valid) @(negedge clk);
    check("R5 first kept", resp_time, conv(48'd111, 40'h00_4000_0000, 64'd77));
    held_time = resp_time;
    for (int i = 0; i < A_W + 5; i++) begin
      @(negedge clk);
      if (resp_valid) pulses++;
    end
    check("R5 no extra result", T_W'(pulses), 0);
    check("R9 held", resp_time, held_time);

    // R3: back-to-back, accept in the result cycle
    @(negedge clk); #1;
    req_valid = 1; req_ts = 48'd5;
    @(negedge clk); #1; req_ts = 48'd6;
    while (!resp_valid) @(negedge clk);
    check("R3 ready in done cycle", T_W'(req_ready), 1);
    @(negedge clk); #1 req_valid = 0;
    check("R3 second accepted", T_W'(req_ready), 0);
    while (!resp_valid) @(negedge clk);
    check("R3 second result", T_W'(resp_raw), 6);

    // R8: negative offset and wrap
    set_shadow(ONE, -64'sd5000, 1);
    run_conv(0, 48'd1000, ONE, -64'sd5000, 0, "R8 negative");
    set_shadow(40'hFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1);
    run_conv(0, 48'hFFFF_FFFF_FFFF, 40'hFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R8 wrap");

    repeat (4) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule